// File: doc/BRIEF.md
# Serial ADC Control Sequencer

This block is the digital sequencer of an eight-input, 12-bit successive-approximation converter with a serial host port. It runs on a fast system clock. It oversamples the host's chip-select, serial clock and data lines and acts on the rising and falling edges of the serial clock that it detects. A host first shifts in an 8-bit command word, most significant bit first. The sequencer decodes the input channel and the mode from that word. In single-ended mode the negative side of the input is analog ground. In differential mode the two inputs are a fixed even/odd channel pair.

The command word also times the sampling switch. The input multiplexer points at the chosen channels on the falling edge after the mode bit. The switch opens (hold) on the falling edge after the last command bit, and at that same edge the sampling node moves to the negative input. A 12-step binary search follows, one step per serial clock, driving a DAC trial code and reading a 1-bit comparator. When the search ends the sampling path returns to the positive input, and the result leaves on the data output, most significant bit first. The analog parts (comparator, DAC, switch) are external and are seen only through ports.

Raising chip-select at any point abandons the transaction. The block then returns to waiting for a start bit, with the switch closed.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, track=1, on_neg=0, dout=0, dac_code=0, pos_ch=0, neg_ch=0 and neg_gnd=1.
- R2: While cs_n is low, data is sampled on sclk rising edges. Zeros ahead of the first 1 are ignored. That first 1 is command bit 7 (start), and the next seven rising edges supply bits 6 down to 0.
- R3: On the sclk falling edge after command bit 3, the multiplexer outputs take the decoded selection. With bit 3 = 1 (single-ended), pos_ch = bits 6:4, neg_ch = 0 and neg_gnd = 1.
- R4: With bit 3 = 0 (differential), pos_ch = bits 6:4, neg_ch = pos_ch with its LSB inverted, and neg_gnd = 0. The selection does not change while the node is on the negative input.
- R5: On the sclk falling edge after command bit 0, track goes to 0 and on_neg goes to 1 in the same clock, and dac_code becomes 0x800. track and on_neg are never 1 together.
- R6: Each of the next 12 sclk falling edges resolves one DAC bit, from MSB to LSB. The bit under trial is kept if cmp_le=1 and cleared if cmp_le=0, and the next lower bit is then set. dac_code holds its value between steps, and after the last step it equals the result.
- R7: On the 12th step edge, track returns to 1, on_neg returns to 0, and dout shows result bit 11. Each later falling edge shows the next lower bit. The falling edge after bit 0 is shown sets dout to 0 and returns the block to idle.
- R8: Command bits 2:0, and din during the conversion and the shift-out, have no effect on the result.
- R9: cs_n high at any point returns the block to idle with track=1, on_neg=0 and dout=0, and discards any partial command. A new transaction again needs a start bit.
- R10: sclk edges while cs_n is high change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from host |
| sclk | input | 1 | Serial clock from host (oversampled) |
| din | input | 1 | Serial command data |
| cmp_le | input | 1 | Comparator: 1 when summing node is at or below zero |
| dout | output | 1 | Serial result data, MSB first |
| track | output | 1 | 1 = sampling switch closed (tracking) |
| on_neg | output | 1 | 1 = sampling node connected to the negative input |
| pos_ch | output | 3 | Positive-input channel select |
| neg_ch | output | 3 | Negative-input channel select (valid when neg_gnd=0) |
| neg_gnd | output | 1 | 1 = negative input tied to analog ground |
| dac_code | output | 12 | DAC trial code |

## Verification
A behavioural comparator holds a per-channel input value. It freezes the difference that the multiplexer selects when the switch opens, so a wrong channel or pair decode gives a wrong serial result and cannot hide. The input patterns are:
- full scale on one channel, which keeps every trial bit;
- zero, which clears every trial bit;
- a difference of exactly one LSB;
- negative differences that clamp to zero;
- two mixed patterns, which separate the even and odd pair members.

Leading zeros, junk in the ignored command bits and junk on din during the conversion check framing. Aborts in the middle of a command and in the middle of a conversion check the return to tracking and the need for a fresh start bit.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CMD   = 2'd1,
      ST_CONV  = 2'd2,
      ST_SHOUT = 2'd3
   } seq_state_t;

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("adc_seq_sync: W must be at least 1");
   end
   if (STAGES < 0) begin : g_bad_st
      $error("adc_seq_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/adc_seq_decode.sv
module adc_seq_decode #(
   parameter int CH_W = 3
) (
   input  logic [CH_W:0]   hdr,
   output logic [CH_W-1:0] pos_sel,
   output logic [CH_W-1:0] neg_sel,
   output logic            neg_to_gnd
);

   logic            single;
   logic [CH_W-1:0] chan;

   assign single = hdr[0];
   assign chan   = hdr[CH_W:1];

   always_comb begin
      pos_sel    = chan;
      neg_to_gnd = single;
      if (single) neg_sel = '0;
      else        neg_sel = {chan[CH_W-1:1], ~chan[0]};
   end

endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
   parameter int RES_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             step,
   input  logic             cmp_le,
   output logic [RES_W-1:0] code,
   output logic [RES_W-1:0] resolved
);

   localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

   logic [RES_W-1:0] mask;

   assign resolved = cmp_le ? code : (code & ~mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
         mask <= '0;
      end else if (start) begin
         code <= TOP_BIT;
         mask <= TOP_BIT;
      end else if (step) begin
         code <= resolved | (mask >> 1);
         mask <= mask >> 1;
      end
   end

   // R6
   mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mask));

   // R6
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(start || step) |=> $stable(code));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int RES_W       = 12,
   parameter int CMD_W       = 8,
   parameter int NUM_CH      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cs_n,
   input  logic                      sclk,
   input  logic                      din,
   input  logic                      cmp_le,
   output logic                      dout,
   output logic                      track,
   output logic                      on_neg,
   output logic [$clog2(NUM_CH)-1:0] pos_ch,
   output logic [$clog2(NUM_CH)-1:0] neg_ch,
   output logic                      neg_gnd,
   output logic [RES_W-1:0]          dac_code
);

   localparam int CH_W    = $clog2(NUM_CH);
   localparam int MAX_CNT = (RES_W > CMD_W) ? RES_W : CMD_W;
   localparam int CNT_W   = $clog2(MAX_CNT + 1);
   localparam logic [CNT_W-1:0] CNT_SEL  = CNT_W'(CH_W + 2);
   localparam logic [CNT_W-1:0] CNT_HOLD = CNT_W'(CMD_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RES_W - 1);

   if (NUM_CH < 2 || NUM_CH != (1 << CH_W)) begin : g_bad_ch
      $error("adc_seq_ctrl: NUM_CH must be a power of two, at least 2");
   end
   if (CMD_W < CH_W + 2) begin : g_bad_cmd
      $error("adc_seq_ctrl: CMD_W too short for start, channel and mode bits");
   end
   if (RES_W < 2) begin : g_bad_res
      $error("adc_seq_ctrl: RES_W must be at least 2");
   end

   // ---------------- input conditioning ----------------
   logic [2:0] pins_s;
   logic       cs_s, sclk_s, din_s, sclk_q;
   logic       rise, fall;

   adc_seq_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, din}),
      .q     (pins_s)
   );

   assign {cs_s, sclk_s, din_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end

   assign rise = !cs_s &&  sclk_s && !sclk_q;
   assign fall = !cs_s && !sclk_s &&  sclk_q;

   // ---------------- sequencer state ----------------
   seq_state_t       state;
   logic [CNT_W-1:0] cnt;
   logic [CMD_W-1:0] sreg;
   logic [RES_W-1:0] res_sh;
   logic             sar_start, sar_step;
   logic [RES_W-1:0] sar_res;
   logic [CH_W-1:0]  dec_pos, dec_neg;
   logic             dec_gnd;

   assign sar_start = (state == ST_CMD)  && fall && (cnt == CNT_HOLD);
   assign sar_step  = (state == ST_CONV) && fall;

   adc_seq_decode #(.CH_W(CH_W)) u_dec (
      .hdr        (sreg[CH_W:0]),
      .pos_sel    (dec_pos),
      .neg_sel    (dec_neg),
      .neg_to_gnd (dec_gnd)
   );

   adc_seq_sar #(.RES_W(RES_W)) u_sar (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (sar_start),
      .step     (sar_step),
      .cmp_le   (cmp_le),
      .code     (dac_code),
      .resolved (sar_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         sreg    <= '0;
         res_sh  <= '0;
         dout    <= 1'b0;
         track   <= 1'b1;
         on_neg  <= 1'b0;
         pos_ch  <= '0;
         neg_ch  <= '0;
         neg_gnd <= 1'b1;
      end else if (cs_s) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         dout   <= 1'b0;
         track  <= 1'b1;
         on_neg <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (rise && din_s) begin
                  state <= ST_CMD;
                  cnt   <= CNT_W'(1);
                  sreg  <= {sreg[CMD_W-2:0], 1'b1};
               end
            end
            ST_CMD: begin
               if (rise && cnt < CNT_HOLD) begin
                  sreg <= {sreg[CMD_W-2:0], din_s};
                  cnt  <= cnt + 1'b1;
               end else if (fall) begin
                  if (cnt == CNT_SEL) begin
                     pos_ch  <= dec_pos;
                     neg_ch  <= dec_neg;
                     neg_gnd <= dec_gnd;
                  end
                  if (cnt == CNT_HOLD) begin
                     state  <= ST_CONV;
                     cnt    <= '0;
                     track  <= 1'b0;
                     on_neg <= 1'b1;
                  end
               end
            end
            ST_CONV: begin
               if (fall) begin
                  if (cnt == CNT_LAST) begin
                     state  <= ST_SHOUT;
                     cnt    <= '0;
                     track  <= 1'b1;
                     on_neg <= 1'b0;
                     res_sh <= sar_res;
                     dout   <= sar_res[RES_W-1];
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_SHOUT: begin
               if (fall) begin
                  if (cnt == CNT_LAST) begin
                     state <= ST_IDLE;
                     cnt   <= '0;
                     dout  <= 1'b0;
                  end else begin
                     cnt    <= cnt + 1'b1;
                     res_sh <= res_sh << 1;
                     dout   <= res_sh[RES_W-2];
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R5
   sw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(track && on_neg));

   // R5
   hold_moves_node_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(track) |-> on_neg);

   // R4
   sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (on_neg && $past(on_neg)) |-> $stable({pos_ch, neg_ch, neg_gnd}));

   // R9
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> (track && !on_neg && !dout));

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !dout);

endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

   localparam int H = 6;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        cs_n  = 1'b1;
   logic        sclk  = 1'b0;
   logic        din   = 1'b0;
   logic        cmp_le;
   logic        dout, track, on_neg, neg_gnd;
   logic [2:0]  pos_ch, neg_ch;
   logic [11:0] dac_code;

   int checks = 0;
   int errors = 0;
   int exp_q[$];
   int ain [8] = '{'h123, 'hFFF, 'h800, 'h7FF, 'h000, 'hA5A, 'h5A5, 'h001};
   int live, held;

   adc_seq_ctrl i_adc_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .cmp_le(cmp_le), .dout(dout), .track(track), .on_neg(on_neg),
      .pos_ch(pos_ch), .neg_ch(neg_ch), .neg_gnd(neg_gnd), .dac_code(dac_code)
   );

   // behavioural analog front end
   always_comb begin
      live = ain[pos_ch] - (neg_gnd ? 0 : ain[neg_ch]);
      if (live < 0) live = 0;
   end
   always @(posedge clk) if (track) held <= live;
   assign cmp_le = (int'(dac_code) <= held);

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic d);
      din = d;
      wt(H);
      sclk = 1'b1;
      wt(H);
      sclk = 1'b0;
   endtask

   function automatic int expect_val(input logic [7:0] w);
      int ch, d;
      ch = int'(w[6:4]);
      if (w[3]) return ain[ch];
      d = ain[ch] - ain[ch ^ 1];
      return (d < 0) ? 0 : d;
   endfunction

   task automatic send_word(input logic [7:0] w, input int lead);
      for (int i = 0; i < lead; i++) pulse(1'b0);
      for (int i = 7; i >= 0; i--) begin
         pulse(w[i]);
         if (i == 3) begin
            wt(H);
            chk("R3 pos_ch", pos_ch, int'(w[6:4]));
            chk("R3/R4 neg_gnd", neg_gnd, int'(w[3]));
            if (!w[3]) chk("R4 neg_ch pair", neg_ch, int'(w[6:4]) ^ 1);
            chk("R2 still tracking", {track, on_neg}, 2'b10);
         end
      end
      wt(H);
      chk("R5 hold and node switch", {track, on_neg}, 2'b01);
      chk("R5 first trial", dac_code, 'h800);
   endtask

   task automatic convert(input logic [7:0] w, input int lead, input logic junk);
      int v;
      v = expect_val(w);
      exp_q.push_back(v);
      send_word(w, lead);
      for (int s = 0; s < 12; s++) begin
         pulse(junk);
         if (s == 0) begin
            wt(H);
            chk("R6 first step", dac_code, (v >= 'h800) ? 'hC00 : 'h400);
         end
      end
      wt(H);
      chk("R7 reconnect to positive", {track, on_neg}, 2'b10);
      chk("R6 final code", dac_code, v);
      for (int s = 0; s < 12; s++) pulse(junk);
      wt(H);
      chk("R7 dout idle after shift-out", dout, 0);
   endtask

   // scoreboard monitor: collects 12 bits on host read edges after reconnect
   initial begin
      int got;
      forever begin
         @(posedge track);
         if (cs_n || !rst_n) continue;
         got = 0;
         repeat (12) begin
            @(posedge sclk);
            got = (got << 1) | int'(dout);
         end
         if (exp_q.size() == 0) chk("R7 unexpected result", got, -1);
         else chk("R7/R8 serial result", got, exp_q.pop_front());
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] part;
      wt(5);
      rst_n = 1'b1;
      wt(3);
      chk("R1 track", track, 1);
      chk("R1 on_neg", on_neg, 0);
      chk("R1 dout", dout, 0);
      chk("R1 dac_code", dac_code, 0);
      chk("R1 select", {pos_ch, neg_ch, neg_gnd}, 7'b000_000_1);

      cs_n = 1'b0;
      wt(H);
      convert(8'b1_000_1_000, 2, 1'b0);   // R2 leading zeros, single-ended ch0
      convert(8'b1_001_1_111, 0, 1'b1);   // R8 junk low bits and din, full scale
      convert(8'b1_100_1_010, 0, 1'b0);   // zero input
      convert(8'b1_010_0_000, 0, 1'b0);   // R4 diff, one LSB
      convert(8'b1_011_0_101, 0, 1'b1);   // R4 diff, negative clamps
      convert(8'b1_101_0_000, 0, 1'b0);   // R4 odd member positive
      convert(8'b1_110_0_000, 0, 1'b0);
      convert(8'b1_111_0_111, 0, 1'b0);
      convert(8'b1_001_0_000, 1, 1'b0);

      // R9: abort inside a command word
      part = 8'b1_011_1_100;
      for (int i = 7; i >= 1; i--) pulse(part[i]);
      cs_n = 1'b1;
      wt(H + 2);
      chk("R9 abort cmd track/node", {track, on_neg}, 2'b10);
      chk("R9 abort cmd dout", dout, 0);
      // R10: sclk activity while deselected
      for (int i = 0; i < 8; i++) pulse(1'b1);
      wt(H);
      chk("R10 deselected select", {pos_ch, neg_gnd}, 4'b011_1);
      chk("R10 deselected switch", {track, on_neg, dout}, 3'b100);
      cs_n = 1'b0;
      wt(H);
      pulse(1'b0);                        // R9: stale bit count must be gone
      convert(8'b1_000_1_000, 0, 1'b0);

      // R9: abort during conversion
      send_word(8'b1_101_1_000, 0);
      for (int i = 0; i < 3; i++) pulse(1'b0);
      cs_n = 1'b1;
      wt(H + 2);
      chk("R9 abort conv track/node", {track, on_neg}, 2'b10);
      cs_n = 1'b0;
      wt(H);
      convert(8'b1_110_0_000, 0, 1'b1);

      wt(4 * H);
      chk("R7 scoreboard drained", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule